// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Positional Tie-Break

This block gathers a set of interrupt request lines (22 by default) and, each time an arbitration strobe arrives, names at most one source to be serviced. The strobe marks an instruction boundary of the processor that owns the block. Every source carries a 3-bit priority level supplied from outside, together with an individual enable. A single global enable gates all of them. A 3-bit current program priority register (CPL) sets the bar that a request must clear: a request can win only when its level value is numerically smaller than the CPL. In this scheme 0 is the most urgent level and 7 the least.

Each source has a sticky pending bit. A rising edge on the request line sets it, and an acknowledge naming that source clears it. The winner of each arbitration is held in registers until it is acknowledged or replaced by the next strobe. When several eligible requests share the best level, a fixed chain order decides between them. The order by index, from the top of the chain down, is: external group A0, A1, B0, B1, C0, C1, D0, D1, then timer 0, serial 0, external 0, external 1, external 2, external 3, external 4, external 5, external 6, external 7, serial 1, ADC, timer 3 and timer 1. Index 0 sits at the top of the chain.

The mode input chooses between two schemes. In concurrent mode the CPL changes only when software writes it. In nested mode an acknowledge raises the CPL to the level of the serviced source and saves the old value on a small stack. A return pulse then restores the saved value.

Top module: `irq_daisy_arb`

## Requirements
- R1: A source's pending bit is set by a 0-to-1 transition of its request line and stays set until an acknowledge carries that source's index. A request line that stays high does not set the bit again.
- R2: A source is eligible when it is pending, its enable bit is 1, the global enable is 1, and its level is numerically less than the CPL. If no source is eligible at a strobe, grant_vld is 0 in the following cycle.
- R3: Among eligible sources, the source with the smallest level value wins.
- R4: Between eligible sources at the same level, the lower index wins. Index 0 is the top of the chain and index 21 is the bottom.
- R5: grant_vld and grant_idx are registered and change in the cycle after a strobe. Without a strobe they stay steady until a matching acknowledge.
- R6: An acknowledge clears the pending bit of ack_idx. If ack_idx equals grant_idx while grant_vld is 1, grant_vld drops in the next cycle. An acknowledge for another index clears only that source's pending bit.
- R7: While the global enable is 0, no grant is made, and pending bits are retained. They win once the enable returns.
- R8: The CPL resets to 7. A write through cpl_wr is visible on cpl_q in the next cycle, in either mode, and takes priority over mode updates.
- R9: In concurrent mode (nest_mode = 0), an acknowledge leaves the CPL unchanged.
- R10: In nested mode, a matching acknowledge loads the CPL with the level captured at arbitration and pushes the old CPL onto a stack of STK_DEPTH entries. A reti pulse pops the stack back into the CPL. A reti with an empty stack leaves the CPL unchanged.
- R11: A strobe in the same cycle as an acknowledge excludes the acknowledged source from that arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NSRC | Request lines, edge sensitive |
| lvl_flat | input | 3*NSRC | Level of source i in bits [3i+2:3i] |
| src_en | input | NSRC | Per-source enable |
| glob_en | input | 1 | Global enable for maskable requests |
| nest_mode | input | 1 | 0 selects concurrent mode, 1 selects nested mode |
| cpl_wr | input | 1 | CPL write strobe |
| cpl_wdata | input | 3 | CPL write value |
| cpl_q | output | 3 | Current program priority |
| arb_stb | input | 1 | Arbitration strobe (instruction boundary) |
| ack | input | 1 | Acknowledge pulse |
| ack_idx | input | IDX_W | Index being acknowledged |
| reti | input | 1 | Return-from-interrupt pulse (nested mode) |
| grant_vld | output | 1 | A winner is held |
| grant_idx | output | IDX_W | Index of the held winner |

## Verification
A lost or stuck pending bit shows up at the next strobe, one cycle later. Either a source that should win never appears on grant_idx, or a source that was already serviced appears again after its acknowledge. A faulty tie-break or level comparison also shows on grant_idx one cycle after the strobe. Draining the full pending set strobe by strobe exposes any position where the order departs from the level-then-index rule. A corrupted CPL or stack entry becomes visible on cpl_q one cycle after the write, acknowledge or reti that should have set it. It also shows at the following strobe, as a grant that is blocked or allowed wrongly.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_RESET = '1;

  // a request beats the program priority when its value is strictly smaller
  function automatic logic lvl_beats(input lvl_t lvl, input lvl_t cpl);
    return lvl < cpl;
  endfunction

  // (level, index) ordering used for the chain tie-break
  function automatic logic ranks_above(input lvl_t la, input lvl_t lb);
    return la < lb;
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N  = 22,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  clr_vec,
  output logic [N-1:0]  pend
);
  logic [N-1:0] req_d;

  always_ff @(posedge clk) begin
    if (!rst_n) req_d <= '0;
    else        req_d <= req;
  end

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic rise;
    assign rise       = req[g] & ~req_d[g];
    assign clr_vec[g] = clr_en && (clr_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)     pend[g] <= 1'b0;
      else if (rise)  pend[g] <= 1'b1;
      else if (clr_vec[g]) pend[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int N  = 22,
  parameter int IW = 5
) (
  input  logic [N-1:0]       elig,
  input  logic [N*LVL_W-1:0] lvl_flat,
  output logic               win_vld,
  output logic [IW-1:0]      win_idx,
  output lvl_t               win_lvl
);
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_lvl = LVL_RESET;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!win_vld || ranks_above(lvl_flat[i*LVL_W +: LVL_W], win_lvl))) begin
        win_vld = 1'b1;
        win_idx = IW'(i);
        win_lvl = lvl_flat[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_cpl_ctrl.sv
module irq_cpl_ctrl
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpl_wr,
  input  lvl_t cpl_wdata,
  input  logic push,
  input  lvl_t push_lvl,
  input  logic pop,
  output lvl_t cpl_q
);
  localparam int CW = $clog2(DEPTH + 1);
  lvl_t          stk [DEPTH];
  logic [CW-1:0] sp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpl_q <= LVL_RESET;
      sp    <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= LVL_RESET;
    end else if (cpl_wr) begin
      cpl_q <= cpl_wdata;
    end else if (push) begin
      cpl_q <= push_lvl;
      if (sp < CW'(DEPTH)) begin
        for (int i = 0; i < DEPTH; i++)
          if (sp == CW'(i)) stk[i] <= cpl_q;
        sp <= sp + 1'b1;
      end
    end else if (pop && sp != '0) begin
      for (int i = 0; i < DEPTH; i++)
        if (sp == CW'(i + 1)) cpl_q <= stk[i];
      sp <= sp - 1'b1;
    end
  end
endmodule

// File: rtl/irq_daisy_arb.sv
module irq_daisy_arb
  import irq_arb_pkg::*;
#(
  parameter int NSRC      = 22,
  parameter int STK_DEPTH = 4,
  parameter int IDX_W     = $clog2(NSRC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       req,
  input  logic [NSRC*LVL_W-1:0] lvl_flat,
  input  logic [NSRC-1:0]       src_en,
  input  logic                  glob_en,
  input  logic                  nest_mode,
  input  logic                  cpl_wr,
  input  logic [LVL_W-1:0]      cpl_wdata,
  output logic [LVL_W-1:0]      cpl_q,
  input  logic                  arb_stb,
  input  logic                  ack,
  input  logic [IDX_W-1:0]      ack_idx,
  input  logic                  reti,
  output logic                  grant_vld,
  output logic [IDX_W-1:0]      grant_idx
);
  logic [NSRC-1:0] pend_q, clr_vec, beat_vec, elig;
  logic            win_vld, ack_hit;
  logic [IDX_W-1:0] win_idx;
  lvl_t            win_lvl, grant_lvl;

  irq_pend_bank #(.N(NSRC), .IW(IDX_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .req(req), .clr_en(ack), .clr_idx(ack_idx),
    .clr_vec(clr_vec), .pend(pend_q)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_beat
    assign beat_vec[g] = lvl_beats(lvl_flat[g*LVL_W +: LVL_W], cpl_q);
  end

  assign elig = pend_q & ~clr_vec & src_en & beat_vec & {NSRC{glob_en}};

  irq_pick #(.N(NSRC), .IW(IDX_W)) u_pick (
    .elig(elig), .lvl_flat(lvl_flat),
    .win_vld(win_vld), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  assign ack_hit = ack && grant_vld && (ack_idx == grant_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_vld <= 1'b0;
      grant_idx <= '0;
      grant_lvl <= LVL_RESET;
    end else if (arb_stb) begin
      grant_vld <= win_vld;
      grant_idx <= win_idx;
      grant_lvl <= win_lvl;
    end else if (ack_hit) begin
      grant_vld <= 1'b0;
    end
  end

  irq_cpl_ctrl #(.DEPTH(STK_DEPTH)) u_cpl (
    .clk(clk), .rst_n(rst_n), .cpl_wr(cpl_wr), .cpl_wdata(cpl_wdata),
    .push(ack_hit && nest_mode), .push_lvl(grant_lvl),
    .pop(reti && nest_mode), .cpl_q(cpl_q)
  );
endmodule

// File: rtl/irq_daisy_arb_chk.sv
module irq_daisy_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int N  = 22,
  parameter int IW = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               arb_stb,
  input logic               glob_en,
  input logic               nest_mode,
  input logic               cpl_wr,
  input logic               ack,
  input logic [IW-1:0]      ack_idx,
  input logic [N*LVL_W-1:0] lvl_flat,
  input logic [LVL_W-1:0]   cpl_q,
  input logic               grant_vld,
  input logic [IW-1:0]      grant_idx,
  input logic [N-1:0]       pend
);
  logic [N*LVL_W-1:0] lvl_d;
  lvl_t               g_lvl_d;
  logic               g_pend, hit;

  always_ff @(posedge clk) lvl_d <= lvl_flat;

  always_comb begin
    g_lvl_d = '0;
    g_pend  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (grant_idx == IW'(i)) begin
        g_lvl_d = lvl_d[i*LVL_W +: LVL_W];
        g_pend  = pend[i];
      end
    end
  end

  assign hit = ack && (ack_idx == grant_idx);

  // R2 R7
  new_grant_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld) |-> $past(arb_stb) && $past(glob_en));

  // R2
  grant_beats_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld) |-> g_lvl_d < $past(cpl_q));

  // R9
  cpl_steady_concurrent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_mode && !cpl_wr) |=> $stable(cpl_q));

  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && !arb_stb && !hit) |=> grant_vld && $stable(grant_idx));

  // R6
  grant_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> g_pend);
endmodule

bind irq_daisy_arb irq_daisy_arb_chk #(.N(NSRC), .IW(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arb_stb(arb_stb), .glob_en(glob_en),
  .nest_mode(nest_mode), .cpl_wr(cpl_wr), .ack(ack), .ack_idx(ack_idx),
  .lvl_flat(lvl_flat), .cpl_q(cpl_q), .grant_vld(grant_vld),
  .grant_idx(grant_idx), .pend(pend_q)
);

// File: tb/irq_daisy_arb_test.sv
module irq_daisy_arb_test;
  localparam int N = 22;
  localparam int IW = 5;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req = '0, src_en = '1;
  logic [N*3-1:0] lvl_flat = '0;
  logic glob_en = 1, nest_mode = 0, cpl_wr = 0, arb_stb = 0, ack = 0, reti = 0;
  logic [2:0] cpl_wdata = '0;
  logic [IW-1:0] ack_idx = '0;
  logic [2:0] cpl_q;
  logic grant_vld;
  logic [IW-1:0] grant_idx;

  int tests = 0, fails = 0;
  bit mpend [N];

  always #10 clk = ~clk;

  irq_daisy_arb uut (
    .clk(clk), .rst_n(rst_n), .req(req), .lvl_flat(lvl_flat), .src_en(src_en),
    .glob_en(glob_en), .nest_mode(nest_mode), .cpl_wr(cpl_wr), .cpl_wdata(cpl_wdata),
    .cpl_q(cpl_q), .arb_stb(arb_stb), .ack(ack), .ack_idx(ack_idx), .reti(reti),
    .grant_vld(grant_vld), .grant_idx(grant_idx)
  );

  task automatic check(string r, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int lvl_of(int i);
    return int'(lvl_flat[i*3 +: 3]);
  endfunction

  // reference: scan levels from most urgent, then chain position
  function automatic int ref_win(int cpl);
    for (int l = 0; l < cpl; l++)
      for (int i = 0; i < N; i++)
        if (mpend[i] && src_en[i] && glob_en && lvl_of(i) == l) return i;
    return -1;
  endfunction

  task automatic pulse(logic [N-1:0] m);
    @(negedge clk) req = req | m;
    @(negedge clk) req = req & ~m;
    for (int i = 0; i < N; i++) if (m[i]) mpend[i] = 1;
  endtask

  task automatic strobe();
    @(negedge clk) arb_stb = 1;
    @(negedge clk) arb_stb = 0;
  endtask

  task automatic do_ack(int i);
    @(negedge clk) begin ack = 1; ack_idx = IW'(i); end
    @(negedge clk) ack = 0;
    mpend[i] = 0;
  endtask

  task automatic wr_cpl(int v);
    @(negedge clk) begin cpl_wr = 1; cpl_wdata = 3'(v); end
    @(negedge clk) cpl_wr = 0;
  endtask

  task automatic grant_is(string r, int e);
    if (e < 0) check(r, int'(grant_vld), 0);
    else begin
      check(r, int'(grant_vld), 1);
      check(r, int'(grant_idx), e);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) if (mpend[i]) do_ack(i);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mpend[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 reset cpl", int'(cpl_q), 7);
    check("R5 reset grant", int'(grant_vld), 0);

    // R4: all at one level, drain in chain order
    for (int i = 0; i < N; i++) lvl_flat[i*3 +: 3] = 3'd3;
    pulse('1);
    for (int k = 0; k < N; k++) begin
      strobe();
      grant_is("R4 chain order", k);
      do_ack(k);
      check("R6 ack drops grant", int'(grant_vld), 0);
    end
    strobe();
    grant_is("R6 all cleared", -1);

    // R3 R2: sweep of level patterns against every CPL value
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < N; i++) lvl_flat[i*3 +: 3] = 3'((i * 3 + c * 5) % 8);
      wr_cpl(c);
      check("R8 cpl write", int'(cpl_q), c);
      pulse('1);
      for (int k = 0; k <= N; k++) begin
        int e;
        e = ref_win(c);
        strobe();
        grant_is("R3 R2 level sweep", e);
        if (e < 0) break;
        do_ack(e);
      end
      clear_all();
    end
    wr_cpl(7);

    // R7: global enable off holds pending
    for (int i = 0; i < N; i++) lvl_flat[i*3 +: 3] = 3'd2;
    glob_en = 0;
    pulse(N'(1) << 4);
    strobe();
    grant_is("R7 masked", -1);
    glob_en = 1;
    strobe();
    grant_is("R7 retained", 4);
    do_ack(4);

    // R2: per-source enable
    lvl_flat[4*3 +: 3] = 3'd1; lvl_flat[9*3 +: 3] = 3'd5;
    src_en[4] = 0;
    pulse((N'(1) << 4) | (N'(1) << 9));
    strobe();
    grant_is("R2 src masked", 9);
    src_en[4] = 1;
    strobe();
    grant_is("R2 src unmasked", 4);
    do_ack(4);
    // R6: ack of a non-granted index clears only that source
    do_ack(9);
    strobe();
    grant_is("R6 other index", -1);

    // R1: held level does not re-pend
    lvl_flat[3*3 +: 3] = 3'd2;
    @(negedge clk) req[3] = 1;
    mpend[3] = 1;
    strobe();
    grant_is("R1 edge sets", 3);
    do_ack(3);
    strobe();
    grant_is("R1 held line", -1);
    @(negedge clk) req[3] = 0;

    // R8 R9: dynamic CPL and concurrent ack
    lvl_flat[6*3 +: 3] = 3'd6;
    wr_cpl(5);
    pulse(N'(1) << 6);
    strobe();
    grant_is("R2 level 6 vs cpl 5", -1);
    wr_cpl(7);
    strobe();
    grant_is("R8 cpl raised", 6);

    // R5: hold without ack, then replaced by next strobe
    repeat (5) @(negedge clk);
    grant_is("R5 hold", 6);
    lvl_flat[12*3 +: 3] = 3'd1;
    pulse(N'(1) << 12);
    grant_is("R5 no strobe no change", 6);
    strobe();
    grant_is("R5 restrobe", 12);
    do_ack(12);
    check("R9 cpl unchanged", int'(cpl_q), 7);
    do_ack(6);

    // R11: strobe coincident with ack
    lvl_flat[2*3 +: 3] = 3'd1; lvl_flat[5*3 +: 3] = 3'd1;
    pulse((N'(1) << 2) | (N'(1) << 5));
    strobe();
    grant_is("R11 first", 2);
    @(negedge clk) begin ack = 1; ack_idx = 2; arb_stb = 1; end
    @(negedge clk) begin ack = 0; arb_stb = 0; end
    mpend[2] = 0;
    grant_is("R11 excluded", 5);
    do_ack(5);

    // R10: nested mode stack
    nest_mode = 1;
    lvl_flat[8*3 +: 3] = 3'd4; lvl_flat[1*3 +: 3] = 3'd2;
    pulse(N'(1) << 8);
    strobe();
    grant_is("R10 first", 8);
    do_ack(8);
    check("R10 cpl loaded", int'(cpl_q), 4);
    pulse(N'(1) << 1);
    strobe();
    grant_is("R10 nested grant", 1);
    do_ack(1);
    check("R10 cpl loaded again", int'(cpl_q), 2);
    @(negedge clk) reti = 1;
    @(negedge clk) reti = 0;
    check("R10 pop one", int'(cpl_q), 4);
    @(negedge clk) reti = 1;
    @(negedge clk) reti = 0;
    check("R10 pop two", int'(cpl_q), 7);
    @(negedge clk) reti = 1;
    @(negedge clk) reti = 0;
    check("R10 pop empty", int'(cpl_q), 7);
    nest_mode = 0;

    summary();
    $finish;
  end
endmodule